// File: doc/BRIEF.md
# DMA Byte Mover with Deferred Write Stage

This block moves one byte per request between a 24-bit system address space (the A side) and an 8-bit peripheral register index space (the B side). A move lasts eight clocks. The source byte is read at the end of the fourth clock. At the end of the eighth clock the resulting write is placed in a single-entry holding stage. The write is not issued right away. It goes out on its bus during the hand-off cycle of the following move, or when a flush is requested. Back-to-back moves therefore overlap the write of byte N with the read side of byte N+1.

An address filter sits between the request and the buses. Some A-side windows map to control registers, and the block never reads them or writes them through its A-side port. Moving between work RAM and B-side index 0x80 is also refused, because both ends share one physical address bus. A blocked read returns zero and no read strobe is issued. A blocked write is stored as an invalid entry and is never issued. The last byte read is kept and driven out as the open-bus value.

A channel sequencer drives the block. It presents direction, index and address with a start pulse, and issues a flush after its last move so that the final write is issued.

Top module: `dma_byte_mover`

## Requirements
- R1: After reset the block is idle (busy low), drives no read or write strobe, holds 0x00 as the open-bus byte, and has no pending write, so a first flush issues no write.
- R2: A start accepted while idle raises busy for exactly 8 cycles. The read strobe is active only in the 4th of these cycles, and the hand-off takes place in the 8th.
- R3: A start pulse while busy is ignored. The running move keeps its captured direction, index and address, and busy falls 8 cycles after the original start.
- R4: An A address is blocked when bit 22 is 0 and the low 16 bits fall in 0x2100-0x21FF, 0x4000-0x41FF, 0x4200-0x421F or 0x4300-0x437F. An A-side read of a blocked address issues no A read strobe and yields 0x00.
- R5: In the B-to-A direction (dir_i=1) the queued write targets the A address and is invalid (never issued) when that address is blocked per R4.
- R6: A move is a work-RAM pair when the index equals 0x80 and the A address has bits 23:17 = 0x3F, or has bit 22 = 0 and bits 15:13 = 0. For such a pair with dir_i=0 the queued B write is invalid. With dir_i=1 no B read strobe is issued and the byte read is 0x00.
- R7: With dir_i=0 the block reads the A address and queues a B write to the move's index, carrying the byte read.
- R8: With dir_i=1 the block reads the B index and queues an A write to the move's address, carrying the byte read.
- R9: A queued valid write is issued with its stored address and data, on exactly one write strobe, in the hand-off cycle of the next move. It is never issued at its own hand-off.
- R10: A flush while idle issues any pending valid write in the same cycle and leaves nothing pending, so a second flush issues nothing.
- R11: The open-bus output holds the byte from the latest read phase (0x00 when that read was blocked) and changes at no other time.
- R12: When start and flush arrive together while idle, the start is taken and the flush is ignored. The pending write is issued only at the new move's hand-off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a move (taken only while idle) |
| flush_i | input | 1 | Issue and clear the pending write (idle only, start wins) |
| dir_i | input | 1 | 0: A to B, 1: B to A |
| bidx_i | input | 8 | B-side register index |
| aaddr_i | input | 24 | A-side address |
| busy_o | output | 1 | Move in progress |
| a_rd_o | output | 1 | A-side read strobe |
| a_raddr_o | output | 24 | A-side read address |
| a_rdata_i | input | 8 | A-side read data |
| b_rd_o | output | 1 | B-side read strobe |
| b_raddr_o | output | 8 | B-side read index |
| b_rdata_i | input | 8 | B-side read data |
| a_wr_o | output | 1 | A-side write strobe |
| a_waddr_o | output | 24 | A-side write address |
| a_wdata_o | output | 8 | A-side write data |
| b_wr_o | output | 1 | B-side write strobe |
| b_waddr_o | output | 8 | B-side write index |
| b_wdata_o | output | 8 | B-side write data |
| mdr_o | output | 8 | Last byte read, used as open-bus value |

## Verification
Two internal states can go wrong here: the holding stage and the phase counter. A stale or dropped entry in the holding stage does not show up when it is written. It shows up one move later, as a missing strobe, an extra strobe or a wrong address or data on the next hand-off. A flush shows it at once. The bench therefore follows every move with a check of the following hand-off. A miscounted phase moves the read strobe or the busy fall by whole cycles, so both are sampled in the exact cycle the requirements name. A wrong filter decision shows within the same move, as a missing or unexpected read strobe and a zero or non-zero open-bus byte.

// File: rtl/dma_mover_pkg.sv
package dma_mover_pkg;

   typedef enum logic {
      DIR_A2B = 1'b0,
      DIR_B2A = 1'b1
   } mv_dir_e;

   localparam int unsigned PKG_ADDR_W   = 24;
   localparam int unsigned NUM_BLOCKED  = 4;

   // Control-register windows that the A port must never touch.
   localparam logic [NUM_BLOCKED-1:0][PKG_ADDR_W-1:0] BLK_MASK = {
      24'h40FF80, 24'h40FFE0, 24'h40FE00, 24'h40FF00
   };
   localparam logic [NUM_BLOCKED-1:0][PKG_ADDR_W-1:0] BLK_MATCH = {
      24'h004300, 24'h004200, 24'h004000, 24'h002100
   };

   // Work-RAM detection: a bank pair, and the low mirror in system banks.
   localparam logic [PKG_ADDR_W-1:0] WRAM_BANK_MASK  = 24'hFE0000;
   localparam logic [PKG_ADDR_W-1:0] WRAM_BANK_MATCH = 24'h7E0000;
   localparam logic [PKG_ADDR_W-1:0] WRAM_LOW_MASK   = 24'h40E000;

   localparam logic [7:0] WRAM_PORT_IDX = 8'h80;

endpackage

// File: rtl/dma_addr_filter.sv
module dma_addr_filter
   import dma_mover_pkg::*;
#(
   parameter int unsigned ADDR_W = 24,
   parameter int unsigned IDX_W  = 8
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [IDX_W-1:0]  idx_i,
   output logic              a_legal_o,
   output logic              pair_ok_o
);

   generate
      if (ADDR_W != PKG_ADDR_W) begin : g_bad_aw
         $error("dma_addr_filter: ADDR_W must equal the package address width");
      end
      if (IDX_W != 8) begin : g_bad_iw
         $error("dma_addr_filter: IDX_W must be 8");
      end
   endgenerate

   logic [NUM_BLOCKED-1:0] win_hit;

   generate
      for (genvar w = 0; w < NUM_BLOCKED; w++) begin : g_win
         assign win_hit[w] = ((addr_i & BLK_MASK[w]) == BLK_MATCH[w]);
      end
   endgenerate

   logic wram_hit;
   assign wram_hit = ((addr_i & WRAM_BANK_MASK) == WRAM_BANK_MATCH) ||
                     ((addr_i & WRAM_LOW_MASK) == '0);

   assign a_legal_o = ~|win_hit;
   assign pair_ok_o = !((idx_i == WRAM_PORT_IDX) && wram_hit);

endmodule

// File: rtl/dma_phase_timer.sv
module dma_phase_timer #(
   parameter int unsigned PHASE_CLKS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic take_o,
   output logic busy_o,
   output logic rd_ph_o,
   output logic wr_ph_o
);

   localparam int unsigned MOVE_CLKS = 2 * PHASE_CLKS;
   localparam int unsigned CNT_W     = $clog2(MOVE_CLKS);

   generate
      if (PHASE_CLKS < 2) begin : g_bad_phase
         $error("dma_phase_timer: PHASE_CLKS must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;

   assign take_o  = start_i && !busy_q;
   assign busy_o  = busy_q;
   assign rd_ph_o = busy_q && (cnt_q == CNT_W'(PHASE_CLKS - 1));
   assign wr_ph_o = busy_q && (cnt_q == CNT_W'(MOVE_CLKS - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (take_o) begin
         busy_q <= 1'b1;
         cnt_q  <= '0;
      end else if (wr_ph_o) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (busy_q) begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end

   // R2: each busy cycle advances the phase by one, start pulses included (R3)
   p_phase_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && !wr_ph_o |=> busy_o && (cnt_q == $past(cnt_q) + 1'b1));

   // R2: the hand-off cycle is the last busy cycle
   p_handoff_ends_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ph_o && !start_i |=> !busy_o);

   // R2: a taken start always opens at phase zero
   p_take_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |=> busy_o && (cnt_q == '0));

endmodule

// File: rtl/dma_write_pipe.sv
module dma_write_pipe #(
   parameter int unsigned ADDR_W = 24,
   parameter int unsigned IDX_W  = 8,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              ent_valid_i,
   input  logic              ent_to_a_i,
   input  logic [ADDR_W-1:0] ent_addr_i,
   input  logic [DATA_W-1:0] ent_data_i,
   output logic              a_wr_o,
   output logic [ADDR_W-1:0] a_waddr_o,
   output logic [DATA_W-1:0] a_wdata_o,
   output logic              b_wr_o,
   output logic [IDX_W-1:0]  b_waddr_o,
   output logic [DATA_W-1:0] b_wdata_o
);

   generate
      if (IDX_W > ADDR_W) begin : g_bad_w
         $error("dma_write_pipe: IDX_W must not exceed ADDR_W");
      end
   endgenerate

   logic              hold_v_q;
   logic              hold_a_q;
   logic [ADDR_W-1:0] hold_addr_q;
   logic [DATA_W-1:0] hold_data_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_v_q    <= 1'b0;
         hold_a_q    <= 1'b0;
         hold_addr_q <= '0;
         hold_data_q <= '0;
      end else if (load_i) begin
         hold_v_q    <= ent_valid_i;
         hold_a_q    <= ent_to_a_i;
         hold_addr_q <= ent_addr_i;
         hold_data_q <= ent_data_i;
      end
   end

   // The held entry is released exactly when it is replaced.
   assign a_wr_o    = load_i && hold_v_q &&  hold_a_q;
   assign b_wr_o    = load_i && hold_v_q && !hold_a_q;
   assign a_waddr_o = hold_addr_q;
   assign a_wdata_o = hold_data_q;
   assign b_waddr_o = hold_addr_q[IDX_W-1:0];
   assign b_wdata_o = hold_data_q;

   // R9: at most one bus receives the released entry
   p_single_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({a_wr_o, b_wr_o}));

   // R10: storing an invalid entry leaves nothing to release
   p_invalid_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
      load_i && !ent_valid_i |=> !hold_v_q);

   // R9: without a load the held entry does not move
   p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(hold_v_q) && $stable(hold_addr_q) && $stable(hold_data_q));

endmodule

// File: rtl/dma_byte_mover.sv
module dma_byte_mover
   import dma_mover_pkg::*;
#(
   parameter int unsigned ADDR_W     = 24,
   parameter int unsigned IDX_W      = 8,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned PHASE_CLKS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              flush_i,
   input  logic              dir_i,
   input  logic [IDX_W-1:0]  bidx_i,
   input  logic [ADDR_W-1:0] aaddr_i,
   output logic              busy_o,
   output logic              a_rd_o,
   output logic [ADDR_W-1:0] a_raddr_o,
   input  logic [DATA_W-1:0] a_rdata_i,
   output logic              b_rd_o,
   output logic [IDX_W-1:0]  b_raddr_o,
   input  logic [DATA_W-1:0] b_rdata_i,
   output logic              a_wr_o,
   output logic [ADDR_W-1:0] a_waddr_o,
   output logic [DATA_W-1:0] a_wdata_o,
   output logic              b_wr_o,
   output logic [IDX_W-1:0]  b_waddr_o,
   output logic [DATA_W-1:0] b_wdata_o,
   output logic [DATA_W-1:0] mdr_o
);

   generate
      if (DATA_W < 1) begin : g_bad_dw
         $error("dma_byte_mover: DATA_W must be positive");
      end
   endgenerate

   // ---------------- phase timing ----------------
   logic take, rd_ph, wr_ph;

   dma_phase_timer #(.PHASE_CLKS(PHASE_CLKS)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .take_o  (take),
      .busy_o  (busy_o),
      .rd_ph_o (rd_ph),
      .wr_ph_o (wr_ph)
   );

   logic flush_take;
   assign flush_take = flush_i && !busy_o && !start_i;

   // ---------------- captured move ----------------
   mv_dir_e           mv_dir_q;
   logic [IDX_W-1:0]  mv_idx_q;
   logic [ADDR_W-1:0] mv_addr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mv_dir_q  <= DIR_A2B;
         mv_idx_q  <= '0;
         mv_addr_q <= '0;
      end else if (take) begin
         mv_dir_q  <= mv_dir_e'(dir_i);
         mv_idx_q  <= bidx_i;
         mv_addr_q <= aaddr_i;
      end
   end

   // ---------------- filtering ----------------
   logic a_legal, pair_ok;

   dma_addr_filter #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_filter (
      .addr_i    (mv_addr_q),
      .idx_i     (mv_idx_q),
      .a_legal_o (a_legal),
      .pair_ok_o (pair_ok)
   );

   // ---------------- read phase ----------------
   logic [DATA_W-1:0] rd_byte;
   logic [DATA_W-1:0] mdr_q;

   assign a_rd_o    = rd_ph && (mv_dir_q == DIR_A2B) && a_legal;
   assign b_rd_o    = rd_ph && (mv_dir_q == DIR_B2A) && pair_ok;
   assign a_raddr_o = mv_addr_q;
   assign b_raddr_o = mv_idx_q;

   always_comb begin
      rd_byte = '0;
      if (a_rd_o)      rd_byte = a_rdata_i;
      else if (b_rd_o) rd_byte = b_rdata_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     mdr_q <= '0;
      else if (rd_ph) mdr_q <= rd_byte;
   end

   assign mdr_o = mdr_q;

   // ---------------- write hand-off ----------------
   logic              ent_valid;
   logic              ent_to_a;
   logic [ADDR_W-1:0] ent_addr;

   always_comb begin
      ent_to_a = (mv_dir_q == DIR_B2A);
      if (ent_to_a) begin
         ent_valid = a_legal;
         ent_addr  = mv_addr_q;
      end else begin
         ent_valid = pair_ok;
         ent_addr  = ADDR_W'(mv_idx_q);
      end
      if (flush_take) ent_valid = 1'b0;
   end

   dma_write_pipe #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_pipe (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (wr_ph || flush_take),
      .ent_valid_i (ent_valid),
      .ent_to_a_i  (ent_to_a),
      .ent_addr_i  (ent_addr),
      .ent_data_i  (mdr_q),
      .a_wr_o      (a_wr_o),
      .a_waddr_o   (a_waddr_o),
      .a_wdata_o   (a_wdata_o),
      .b_wr_o      (b_wr_o),
      .b_waddr_o   (b_waddr_o),
      .b_wdata_o   (b_wdata_o)
   );

   // R2: reads occur only inside a move
   p_read_in_move_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (a_rd_o || b_rd_o) |-> busy_o);

   // R4: never two reads at once
   p_read_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({a_rd_o, b_rd_o}));

   // R11: a blocked read phase leaves zero as open-bus byte
   p_blocked_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ph && !a_rd_o && !b_rd_o |=> mdr_o == '0);

   // R11: the open-bus byte moves only after a read phase
   p_mdr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_ph |=> $stable(mdr_o));

   // R9: writes appear only at hand-off or on an accepted flush
   p_write_when_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (a_wr_o || b_wr_o) |-> (wr_ph || (flush_i && !busy_o && !start_i)));

endmodule

// File: tb/dma_byte_mover_bench.sv
`timescale 1ns/1ps
module dma_byte_mover_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        start_i, flush_i, dir_i;
   logic [7:0]  bidx_i;
   logic [23:0] aaddr_i;
   logic        busy_o, a_rd_o, b_rd_o, a_wr_o, b_wr_o;
   logic [23:0] a_raddr_o, a_waddr_o;
   logic [7:0]  b_raddr_o, b_waddr_o, a_wdata_o, b_wdata_o, mdr_o;
   logic [7:0]  a_rdata_i, b_rdata_i;

   always #5 clk = ~clk;

   dma_byte_mover u_dma_byte_mover (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .flush_i(flush_i),
      .dir_i(dir_i), .bidx_i(bidx_i), .aaddr_i(aaddr_i), .busy_o(busy_o),
      .a_rd_o(a_rd_o), .a_raddr_o(a_raddr_o), .a_rdata_i(a_rdata_i),
      .b_rd_o(b_rd_o), .b_raddr_o(b_raddr_o), .b_rdata_i(b_rdata_i),
      .a_wr_o(a_wr_o), .a_waddr_o(a_waddr_o), .a_wdata_o(a_wdata_o),
      .b_wr_o(b_wr_o), .b_waddr_o(b_waddr_o), .b_wdata_o(b_wdata_o),
      .mdr_o(mdr_o)
   );

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   // bench-side model of the pending write
   bit         pv;
   bit         pa;
   logic [23:0] paddr;
   logic [7:0]  pdat;
   logic [7:0]  mdr_exp;

   // {dir, idx, addr, rdata}
   localparam int NV = 11;
   localparam logic [40:0] VEC [NV] = '{
      {1'b0, 8'h18, 24'h7F1234, 8'h5A},
      {1'b0, 8'h80, 24'h7E0010, 8'h33},
      {1'b0, 8'h04, 24'h002105, 8'hEE},
      {1'b1, 8'h39, 24'h7E8000, 8'hC3},
      {1'b1, 8'h80, 24'h001000, 8'h44},
      {1'b1, 8'h22, 24'h804300, 8'h77},
      {1'b0, 8'h00, 24'h0041A0, 8'h66},
      {1'b0, 8'h01, 24'h00421F, 8'h55},
      {1'b0, 8'h02, 24'h404200, 8'h99},
      {1'b1, 8'h80, 24'h7F0000, 8'h11},
      {1'b1, 8'h81, 24'h7F0000, 8'h12}
   };

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic bit blocked(input logic [23:0] a);
      if (a[22]) return 1'b0;
      return (a[15:8] == 8'h21) || (a[15:9] == 7'h20) ||
             (a[15:5] == 11'h210) || (a[15:7] == 9'h086);
   endfunction

   function automatic bit wram_pair(input logic [7:0] i, input logic [23:0] a);
      return (i == 8'h80) && ((a[23:17] == 7'h3F) || (!a[22] && a[15:13] == 3'b000));
   endfunction

   task automatic check_release(input string req);
      chk(a_wr_o == (pv && pa),  req, "a_wr", 32'(a_wr_o), 32'(pv && pa));
      chk(b_wr_o == (pv && !pa), req, "b_wr", 32'(b_wr_o), 32'(pv && !pa));
      if (pv && pa) begin
         chk(a_waddr_o == paddr, req, "a_waddr", 32'(a_waddr_o), 32'(paddr));
         chk(a_wdata_o == pdat,  req, "a_wdata", 32'(a_wdata_o), 32'(pdat));
      end else if (pv) begin
         chk(b_waddr_o == paddr[7:0], req, "b_waddr", 32'(b_waddr_o), 32'(paddr[7:0]));
         chk(b_wdata_o == pdat,       req, "b_wdata", 32'(b_wdata_o), 32'(pdat));
      end
   endtask

   // intrude: pulse start mid-move (R3); with_flush: flush with start (R12)
   task automatic run_move(input logic d, input logic [7:0] idx, input logic [23:0] ad,
                           input logic [7:0] rd, input bit intrude, input bit with_flush);
      bit legal, pok, exp_ard, exp_brd, nv;
      logic [7:0] byte_exp;
      legal = !blocked(ad);
      pok   = !wram_pair(idx, ad);
      exp_ard = (d == 1'b0) && legal;
      exp_brd = (d == 1'b1) && pok;
      byte_exp = (exp_ard || exp_brd) ? rd : 8'h00;
      nv = d ? legal : pok;

      @(negedge clk);
      dir_i = d; bidx_i = idx; aaddr_i = ad;
      a_rdata_i = rd; b_rdata_i = rd;
      start_i = 1'b1; flush_i = with_flush;
      #1;
      if (with_flush)
         chk(!a_wr_o && !b_wr_o, "R12", "write on start+flush", 32'({a_wr_o, b_wr_o}), 0);
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0; flush_i = 1'b0;
      #1;
      chk(busy_o == 1'b1, "R2", "busy after start", 32'(busy_o), 1);
      for (int c = 1; c <= 7; c++) begin
         @(posedge clk);
         @(negedge clk);
         if (intrude && c == 1) begin
            start_i = 1'b1; dir_i = ~d; aaddr_i = 24'h123456; bidx_i = 8'h5C;
         end
         if (intrude && c == 2) begin
            start_i = 1'b0;
         end
         #1;
         if (c == 1)
            chk(!a_rd_o && !b_rd_o && busy_o, "R2", "quiet phase",
                32'({busy_o, a_rd_o, b_rd_o}), 32'h4);
         if (c == 3) begin
            chk(a_rd_o == exp_ard, d ? "R8" : "R4", "a_rd", 32'(a_rd_o), 32'(exp_ard));
            chk(b_rd_o == exp_brd, d ? "R6" : "R7", "b_rd", 32'(b_rd_o), 32'(exp_brd));
            if (exp_ard) chk(a_raddr_o == ad, intrude ? "R3" : "R7", "a_raddr",
                             32'(a_raddr_o), 32'(ad));
            if (exp_brd) chk(b_raddr_o == idx, intrude ? "R3" : "R8", "b_raddr",
                             32'(b_raddr_o), 32'(idx));
         end
         if (c == 7) begin
            chk(busy_o == 1'b1, "R2", "busy in hand-off", 32'(busy_o), 1);
            check_release("R9");
         end
      end
      @(posedge clk);
      @(negedge clk);
      #1;
      chk(busy_o == 1'b0, intrude ? "R3" : "R2", "busy after 8", 32'(busy_o), 0);
      chk(mdr_o == byte_exp, "R11", "open-bus byte", 32'(mdr_o), 32'(byte_exp));
      chk(!a_wr_o && !b_wr_o, "R9", "no write at own hand-off", 32'({a_wr_o, b_wr_o}), 0);
      pv = nv; pa = d; paddr = d ? ad : {16'h0, idx}; pdat = byte_exp; mdr_exp = byte_exp;
   endtask

   task automatic do_flush(input string req);
      @(negedge clk);
      flush_i = 1'b1;
      #1;
      check_release(req);
      @(posedge clk);
      @(negedge clk);
      flush_i = 1'b0;
      pv = 1'b0;
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog run did not complete");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; start_i = 1'b0; flush_i = 1'b0; dir_i = 1'b0;
      bidx_i = '0; aaddr_i = '0; a_rdata_i = '0; b_rdata_i = '0;
      pv = 1'b0; pa = 1'b0; paddr = '0; pdat = '0; mdr_exp = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset state
      chk(busy_o == 1'b0, "R1", "busy", 32'(busy_o), 0);
      chk({a_rd_o, b_rd_o, a_wr_o, b_wr_o} == 4'b0, "R1", "strobes",
          32'({a_rd_o, b_rd_o, a_wr_o, b_wr_o}), 0);
      chk(mdr_o == 8'h00, "R1", "mdr", 32'(mdr_o), 0);
      do_flush("R1");

      // table walk: R4..R9, R11
      for (int v = 0; v < NV; v++)
         run_move(VEC[v][40], VEC[v][39:32], VEC[v][31:8], VEC[v][7:0], 1'b0, 1'b0);

      // R10: flush releases the last pending write, then nothing
      do_flush("R10");
      do_flush("R10");

      // R5: B-to-A into a blocked window never writes
      run_move(1'b1, 8'h10, 24'h002100, 8'hA5, 1'b0, 1'b0);
      do_flush("R5");

      // R3: start pulse during a move is ignored
      run_move(1'b0, 8'h2A, 24'h7E4000, 8'h3C, 1'b1, 1'b0);

      // R12: start and flush together; pending released at next hand-off
      run_move(1'b1, 8'h07, 24'h018000, 8'hB7, 1'b0, 1'b1);
      do_flush("R10");

      // R11: idle time leaves the open-bus byte unchanged
      repeat (5) @(posedge clk);
      @(negedge clk);
      chk(mdr_o == mdr_exp, "R11", "mdr held idle", 32'(mdr_o), 32'(mdr_exp));

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule